// File: doc/BRIEF.md
# Byte-Wide Parallel ADC Read Sequencer

This block sits in an FPGA next to a 16-bit successive-approximation converter whose result comes out over an 8-bit bus. Chip-select and read-enable are tied low at the converter. The interface therefore has only the active-low convert-start line, a byte-select line and eight data lines, plus an optional busy input. The block pulses convert-start at a programmable cycle period. It picks up the upper byte with byte-select low, raises byte-select, picks up the lower byte and drops byte-select again. It then presents the assembled 16-bit word with a one-cycle valid strobe.

All timing is counted in clock cycles: period, low width, post-start quiet window, bus settle time after a byte-select change, and an extra round-trip delay for isolators in the path. Every edge the block drives is placed outside the quiet window. A timed mode reads the previous result early in each period and ignores busy. A busy mode waits for busy to fall and reads the result just completed. In busy mode the period stretches if the read has not finished. A configuration check refuses any timing set whose reads cannot fit inside the period.

Top module: `adcByteReader`

## Requirements
- R1: While reset is held and right after it, convstN is 1, byteSel is 0, sampleValid is 0 and overrun is 0.
- R2: cfgError is 1 exactly when the configuration breaks any of these rules: cfgLowWidth >= 1, cfgLowWidth >= cfgQuiet, cfgLowWidth < cfgPeriod, or cfgQuiet + 2*cfgIsoDelay + cfgSettle + 4 <= cfgPeriod. No conversion starts while cfgError is 1.
- R3: In timed mode (timedMode = 1), convstN falls once every cfgPeriod cycles and stays low for exactly cfgLowWidth cycles.
- R4: Counting the first low cycle of convstN as cycle 0, neither byteSel nor convstN changes value in any cycle before cycle cfgQuiet.
- R5: byteSel is 0 whenever convstN falls. The upper byte is taken with byteSel = 0 and the lower byte with byteSel = 1. sampleData = {upper byte, lower byte}.
- R6: The lower byte is taken from the bus in cycle cfgSettle + cfgIsoDelay, counting the first cycle with byteSel high as cycle 0. The upper byte is taken cfgIsoDelay + 1 cycles after the read is armed.
- R7: In timed mode busy is ignored. The read is armed in cycle cfgQuiet after the fall. sampleValid pulses in cycle cfgQuiet + 3 + 2*cfgIsoDelay + cfgSettle, carrying the result already on the bus, i.e. the previous conversion.
- R8: In busy mode (timedMode = 0), the read is armed in the first cycle B >= cfgQuiet in which busy is low after having been high. sampleValid pulses in cycle B + 3 + 2*cfgIsoDelay + cfgSettle, carrying the conversion just completed.
- R9: In busy mode, the interval from one convstN fall to the next is max(cfgPeriod, B + 4 + 2*cfgIsoDelay + cfgSettle).
- R10: sampleValid is high for single cycles. overrun becomes 1 when a new word completes while the previous word has not been acknowledged with sampleAck. Once set, overrun stays 1 until reset.
- R11: While enable is 0, no new conversion starts. The period already under way completes its read, after which convstN stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows new conversions to start |
| timedMode | input | 1 | 1 = timed reads ignoring busy, 0 = busy-driven reads |
| cfgPeriod | input | CNT_W | Convert-start period in cycles |
| cfgLowWidth | input | CNT_W | Convert-start low width in cycles |
| cfgQuiet | input | CNT_W | Quiet window after the convert-start fall, in cycles |
| cfgSettle | input | CNT_W | Bus settle time after a byte-select change, in cycles |
| cfgIsoDelay | input | CNT_W | Added isolator delay per direction, in cycles |
| adcBusy | input | 1 | Converter busy, synchronous to clk |
| adcData | input | BYTE_W | Converter data bus |
| sampleAck | input | 1 | Consumer acknowledges the presented word |
| convstN | output | 1 | Active-low convert-start |
| byteSel | output | 1 | 0 selects the upper byte, 1 the lower byte |
| sampleData | output | 2*BYTE_W | Assembled result, upper byte first |
| sampleValid | output | 1 | One-cycle strobe for a new word |
| overrun | output | 1 | Sticky: a word completed before the previous one was acknowledged |
| cfgError | output | 1 | Current configuration is rejected |

## Verification
The hardest situation to reach is a busy-mode period that must stretch. This needs the converter's busy to fall so late that the two byte reads cannot finish inside the programmed period. The bench contains a converter model whose conversion length is a bench variable. Setting that length well beyond the period forces the stretch, and the fall-to-fall spacing is then compared with the maximum formula. The model also corrupts the bus for exactly the settle-plus-isolator interval after each byte-select change. A lower byte taken one cycle early therefore shows up as a data mismatch, not only as a timing one.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  typedef struct packed {
    logic grabHi;
    logic grabLo;
  } seqStrobes_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ARM,
    SQ_UPPER,
    SQ_LOWER,
    SQ_DONE
  } seqState_t;

endpackage

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             timedMode,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgLowWidth,
  input  logic [CNT_W-1:0] cfgQuiet,
  input  logic [CNT_W-1:0] cfgSettle,
  input  logic [CNT_W-1:0] cfgIsoDelay,
  input  logic             adcBusy,
  output logic             convstN,
  output logic             byteSel,
  output logic             cfgError,
  output seqStrobes_t      strobes
);

  localparam int EXT_W = CNT_W + 3;

  seqState_t        state;
  logic [CNT_W-1:0] tick;
  logic [CNT_W-1:0] stepCnt;
  logic [CNT_W-1:0] perL, lowL, quietL, settleL, isoL;
  logic             timedL;
  logic             prevBusy;
  logic             busySeen;

  // configuration check on the live inputs
  logic [EXT_W-1:0] needCycles;
  logic             cfgOk;
  always_comb begin
    needCycles = EXT_W'(cfgQuiet) + (EXT_W'(cfgIsoDelay) << 1)
               + EXT_W'(cfgSettle) + EXT_W'(4);
    cfgOk = (cfgLowWidth != '0) && (cfgLowWidth >= cfgQuiet) &&
            (cfgLowWidth < cfgPeriod) && (needCycles <= EXT_W'(cfgPeriod));
  end
  assign cfgError = !cfgOk;

  logic [CNT_W:0] tickNext;
  logic [CNT_W:0] loDelay;
  logic           periodReached;
  logic           fallNow;
  logic           armGo;
  logic           launch;

  always_comb begin
    tickNext      = {1'b0, tick} + (CNT_W+1)'(1);
    loDelay       = {1'b0, settleL} + {1'b0, isoL};
    periodReached = tickNext >= {1'b0, perL};
    fallNow       = prevBusy && !adcBusy;
    armGo         = (tick >= quietL) && (timedL || busySeen || fallNow);
    launch        = enable && cfgOk &&
                    ((state == SQ_IDLE) || ((state == SQ_DONE) && periodReached));
    strobes.grabHi = (state == SQ_UPPER) && (stepCnt == '0);
    strobes.grabLo = (state == SQ_LOWER) && (stepCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      convstN  <= 1'b1;
      byteSel  <= 1'b0;
      tick     <= '0;
      stepCnt  <= '0;
      perL     <= '0;
      lowL     <= '0;
      quietL   <= '0;
      settleL  <= '0;
      isoL     <= '0;
      timedL   <= 1'b0;
      prevBusy <= 1'b0;
      busySeen <= 1'b0;
    end else begin
      prevBusy <= adcBusy;
      if (state != SQ_IDLE) begin
        if (tick != '1) tick <= tick + 1'b1;
        if (tickNext == {1'b0, lowL}) convstN <= 1'b1;
        if (fallNow) busySeen <= 1'b1;
      end
      case (state)
        SQ_ARM: begin
          if (armGo) begin
            state   <= SQ_UPPER;
            stepCnt <= isoL;
          end
        end
        SQ_UPPER: begin
          if (stepCnt == '0) begin
            byteSel <= 1'b1;
            stepCnt <= loDelay[CNT_W-1:0];
            state   <= SQ_LOWER;
          end else begin
            stepCnt <= stepCnt - 1'b1;
          end
        end
        SQ_LOWER: begin
          if (stepCnt == '0) begin
            byteSel <= 1'b0;
            state   <= SQ_DONE;
          end else begin
            stepCnt <= stepCnt - 1'b1;
          end
        end
        SQ_DONE: begin
          if (periodReached) state <= SQ_IDLE;
        end
        default: ;
      endcase
      if (launch) begin
        state    <= SQ_ARM;
        convstN  <= 1'b0;
        tick     <= '0;
        busySeen <= 1'b0;
        perL     <= cfgPeriod;
        lowL     <= cfgLowWidth;
        quietL   <= cfgQuiet;
        settleL  <= cfgSettle;
        isoL     <= cfgIsoDelay;
        timedL   <= timedMode;
      end
    end
  end

  assert_idle_convst_high_R2: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE) |-> convstN);

  assert_quiet_bytesel_R4: assert property (@(posedge clk) disable iff (rst)
    ((state != SQ_IDLE) && (tick != '0) && (tick < quietL)) |-> $stable(byteSel));

  assert_quiet_convst_R4: assert property (@(posedge clk) disable iff (rst)
    ((state != SQ_IDLE) && (tick != '0) && (tick < quietL)) |-> $stable(convstN));

  assert_bytesel_low_at_start_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(convstN) |-> !byteSel);

  assert_grab_hi_select_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.grabHi |-> !byteSel);

  assert_grab_lo_select_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.grabLo |-> byteSel);

  assert_busy_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (strobes.grabHi && !timedL) |-> busySeen);

endmodule

// File: rtl/adcSeqData.sv
module adcSeqData
  import adcSeqPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  seqStrobes_t         strobes,
  input  logic [BYTE_W-1:0]   adcData,
  input  logic                sampleAck,
  output logic [2*BYTE_W-1:0] sampleData,
  output logic                sampleValid,
  output logic                overrun
);

  logic [BYTE_W-1:0] hiByte;
  logic              pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      hiByte      <= '0;
      sampleData  <= '0;
      sampleValid <= 1'b0;
      pending     <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      sampleValid <= strobes.grabLo;
      if (strobes.grabHi) hiByte <= adcData;
      if (strobes.grabLo) sampleData <= {hiByte, adcData};
      pending <= strobes.grabLo || (pending && !sampleAck);
      if (strobes.grabLo && pending && !sampleAck) overrun <= 1'b1;
    end
  end

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_word_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !strobes.grabLo |=> $stable(sampleData));

endmodule

// File: rtl/adcByteReader.sv
module adcByteReader
  import adcSeqPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                timedMode,
  input  logic [CNT_W-1:0]    cfgPeriod,
  input  logic [CNT_W-1:0]    cfgLowWidth,
  input  logic [CNT_W-1:0]    cfgQuiet,
  input  logic [CNT_W-1:0]    cfgSettle,
  input  logic [CNT_W-1:0]    cfgIsoDelay,
  input  logic                adcBusy,
  input  logic [BYTE_W-1:0]   adcData,
  input  logic                sampleAck,
  output logic                convstN,
  output logic                byteSel,
  output logic [2*BYTE_W-1:0] sampleData,
  output logic                sampleValid,
  output logic                overrun,
  output logic                cfgError
);

  seqStrobes_t strobes;

  adcSeqCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .timedMode(timedMode),
    .cfgPeriod(cfgPeriod), .cfgLowWidth(cfgLowWidth), .cfgQuiet(cfgQuiet),
    .cfgSettle(cfgSettle), .cfgIsoDelay(cfgIsoDelay), .adcBusy(adcBusy),
    .convstN(convstN), .byteSel(byteSel), .cfgError(cfgError), .strobes(strobes)
  );

  adcSeqData #(.BYTE_W(BYTE_W)) u_data (
    .clk(clk), .rst(rst), .strobes(strobes), .adcData(adcData),
    .sampleAck(sampleAck), .sampleData(sampleData),
    .sampleValid(sampleValid), .overrun(overrun)
  );

endmodule

// File: tb/adcByteReader_tb.sv
module adcByteReader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic timedMode = 1'b1;
  logic [CNT_W-1:0] cfgPeriod = 16'd10, cfgLowWidth = 16'd2, cfgQuiet = 16'd1;
  logic [CNT_W-1:0] cfgSettle = 16'd1, cfgIsoDelay = 16'd0;
  logic adcBusy = 1'b0;
  logic [7:0] adcData = 8'h00;
  logic sampleAck = 1'b1;
  logic convstN, byteSel, sampleValid, overrun, cfgError;
  logic [15:0] sampleData;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcByteReader u_dut (
    .clk(clk), .rst(rst), .enable(enable), .timedMode(timedMode),
    .cfgPeriod(cfgPeriod), .cfgLowWidth(cfgLowWidth), .cfgQuiet(cfgQuiet),
    .cfgSettle(cfgSettle), .cfgIsoDelay(cfgIsoDelay), .adcBusy(adcBusy),
    .adcData(adcData), .sampleAck(sampleAck), .convstN(convstN),
    .byteSel(byteSel), .sampleData(sampleData), .sampleValid(sampleValid),
    .overrun(overrun), .cfgError(cfgError)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench copy of the active configuration
  int cQuiet = 1, cIso = 0, cSettle = 1, cLow = 2, cPeriod = 10, cConv = 9;
  bit cTimed = 1;

  int validsSeen = 0;
  int fallsSeen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wordOf(input int k);
    return 16'h3C5A + 16'(k) * 16'h0B17;
  endfunction

  // converter model and monitor, all at the falling edge
  initial begin
    int convIdx, tickB, convTimer, since, expInt, expTick;
    bit haveFall, busyM, prevConvN, prevSel, prevValid, fall;
    logic [15:0] latest, expWord;
    logic [7:0] rightByte;
    convIdx = 0; tickB = 0; convTimer = 0; since = 1000;
    haveFall = 0; busyM = 0; prevConvN = 1; prevSel = 0; prevValid = 0;
    latest = wordOf(0);
    forever begin
      @(negedge clk);
      if (rst) begin
        convIdx = 0; tickB = 0; convTimer = 0; since = 1000;
        haveFall = 0; busyM = 0; prevConvN = 1; prevSel = 0; prevValid = 0;
        latest = wordOf(0);
        adcBusy = 1'b0;
        adcData = latest[15:8];
      end else begin
        fall = prevConvN && !convstN;
        if (fall) begin
          if (haveFall) begin
            expInt = cPeriod;
            if (!cTimed && (cConv + 4 + 2*cIso + cSettle > cPeriod))
              expInt = cConv + 4 + 2*cIso + cSettle;
            chk(tickB + 1 == expInt, cTimed ? "R3 period" : "R9 period", tickB + 1, expInt);
          end
          chk(byteSel == 1'b0, "R5 byteSel at fall", byteSel, 0);
          tickB = 0; haveFall = 1; convIdx++; convTimer = 0; busyM = 1;
          fallsSeen++;
        end else begin
          if (tickB < 100000) tickB++;
          if (busyM) begin
            convTimer++;
            if (convTimer == cConv) begin
              busyM = 0;
              latest = wordOf(convIdx);
            end
          end
        end
        if (haveFall && !prevConvN && convstN) begin
          chk(tickB == cLow, "R3 low width", tickB, cLow);
          chk(tickB >= cQuiet, "R4 convstN rise in quiet", tickB, cQuiet);
        end
        if (byteSel != prevSel) begin
          if (haveFall) chk(tickB >= cQuiet, "R4 byteSel edge in quiet", tickB, cQuiet);
          since = 0;
        end else if (since < 1000) begin
          since++;
        end
        if (sampleValid) begin
          chk(!prevValid, "R10 valid single cycle", 1, 0);
          expWord = cTimed ? wordOf(convIdx - 1) : wordOf(convIdx);
          expTick = cTimed ? (cQuiet + 3 + 2*cIso + cSettle)
                           : (cConv + 3 + 2*cIso + cSettle);
          chk(sampleData == expWord, cTimed ? "R7 R6 R5 data" : "R8 R6 R5 data",
              sampleData, expWord);
          chk(tickB == expTick, cTimed ? "R7 valid cycle" : "R8 valid cycle", tickB, expTick);
          validsSeen++;
        end
        adcBusy = busyM;
        rightByte = byteSel ? latest[7:0] : latest[15:8];
        adcData = (since < cSettle + cIso) ? ~rightByte : rightByte;
        prevConvN = convstN; prevSel = byteSel; prevValid = sampleValid;
      end
    end
  end

  task automatic applyCfg(input bit timed, input int q, input int iso, input int st,
                          input int low, input int per, input int conv);
    @(negedge clk);
    enable = 1'b0;
    rst = 1'b1;
    cTimed = timed; cQuiet = q; cIso = iso; cSettle = st; cLow = low;
    cPeriod = per; cConv = conv;
    timedMode = timed;
    cfgQuiet = 16'(q); cfgIsoDelay = 16'(iso); cfgSettle = 16'(st);
    cfgLowWidth = 16'(low); cfgPeriod = 16'(per);
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic waitValids(input int n);
    int guard = 0;
    while (validsSeen < n && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(validsSeen >= n, "R3 progress", validsSeen, n);
  endtask

  task automatic runCfg(input bit timed, input int q, input int iso, input int st,
                        input int per, input int conv);
    int startV, fallsAt;
    applyCfg(timed, q, iso, st, q + 1, per, conv);
    @(negedge clk);
    chk(cfgError == 1'b0, "R2 valid cfg accepted", cfgError, 0);
    startV = validsSeen;
    enable = 1'b1;
    waitValids(startV + 4);
    enable = 1'b0;
    repeat (per + conv + 30) @(negedge clk);
    fallsAt = fallsSeen;
    repeat (2 * per + 10) @(negedge clk);
    chk(fallsSeen == fallsAt, "R11 no start while disabled", fallsSeen, fallsAt);
    chk(convstN == 1'b1, "R11 convstN idle high", convstN, 1);
    chk(overrun == 1'b0, "R10 no overrun with ack", overrun, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(convstN == 1'b1, "R1 convstN in reset", convstN, 1);
    chk(byteSel == 1'b0, "R1 byteSel in reset", byteSel, 0);
    chk(sampleValid == 1'b0, "R1 valid in reset", sampleValid, 0);
    chk(overrun == 1'b0, "R1 overrun in reset", overrun, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(convstN == 1'b1 && byteSel == 1'b0, "R1 after reset", {convstN, byteSel}, 2);

    // enable low with a valid configuration: nothing starts (R11)
    repeat (30) @(negedge clk);
    chk(fallsSeen == 0, "R11 idle without enable", fallsSeen, 0);

    // rejected configurations (R2)
    applyCfg(1, 2, 0, 1, 0, 12, 11);
    @(negedge clk);
    chk(cfgError == 1'b1, "R2 zero low width", cfgError, 1);
    applyCfg(1, 3, 0, 1, 2, 12, 11);
    @(negedge clk);
    chk(cfgError == 1'b1, "R2 low width below quiet", cfgError, 1);
    applyCfg(1, 2, 1, 2, 3, 9, 8);
    @(negedge clk);
    chk(cfgError == 1'b1, "R2 period one short", cfgError, 1);
    applyCfg(1, 2, 1, 2, 10, 10, 9);
    @(negedge clk);
    chk(cfgError == 1'b1, "R2 low width equals period", cfgError, 1);
    enable = 1'b1;
    repeat (40) @(negedge clk);
    chk(fallsSeen == 0, "R2 no start on bad cfg", fallsSeen, 0);
    chk(convstN == 1'b1, "R2 convstN stays high", convstN, 1);
    enable = 1'b0;

    // timed-mode sweep, including period at its minimum
    for (int q = 1; q <= 3; q += 2)
      for (int iso = 0; iso <= 2; iso += 2)
        for (int st = 1; st <= 2; st++)
          for (int ex = 0; ex <= 3; ex += 3)
            runCfg(1, q, iso, st, q + 2*iso + st + 4 + ex, q + 2*iso + st + 4 + ex - 1);

    // busy-mode sweep, short and stretching conversions
    for (int iso = 0; iso <= 1; iso++)
      for (int st = 1; st <= 2; st++)
        for (int cv = 4; cv <= 14; cv += 10)
          runCfg(0, 2, iso, st, 2 + 2*iso + st + 6, cv);

    // overrun when the consumer does not acknowledge (R10)
    sampleAck = 1'b0;
    applyCfg(1, 1, 0, 1, 2, 8, 7);
    enable = 1'b1;
    begin
      int v0;
      v0 = validsSeen;
      waitValids(v0 + 1);
      chk(overrun == 1'b0, "R10 first word no overrun", overrun, 0);
      waitValids(v0 + 2);
      @(negedge clk);
      chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
      sampleAck = 1'b1;
      waitValids(v0 + 4);
      @(negedge clk);
      chk(overrun == 1'b1, "R10 overrun sticky", overrun, 1);
    end
    enable = 1'b0;
    repeat (30) @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule